// File: doc/BRIEF.md
# SMBus Master Clock Phase Generator

This block produces the clock-line behaviour of a two-wire bus master. It does not count time itself. It picks one of four external timer overflow strobes and paces each half-period of SCL by counting those strobes. The block does not drive a pad. It raises a drive-low request that an open-drain cell turns into a pull-down, and it reads the real line level back through `scl_in`. Two single-cycle strobes tell a byte engine when to change SDA, after a falling edge, and when to sample it, in the middle of the high phase.

With no other device on the bus, the low phase lasts one overflow period and the high phase lasts two, so one bit takes three overflow periods. A slave that holds the line low keeps the high phase from starting. The high phase is counted only once the line is actually seen high. If another master pulls the line low during the high phase, the low phase restarts at once, which keeps the two clocks in step. An extended-hold mode adds one overflow period to the low phase. SDA then changes one overflow after the fall, and the setup time before the rise grows by the same amount.

Top module: `smb_scl_gen`

## Requirements
- R1: `src_sel` picks the strobe bit `ovf_strobe[src_sel]`. Bit 0 is timer 0 overflow, bit 1 is timer 1 overflow, bit 2 is the timer 2 high-byte overflow and bit 3 is the timer 2 low-byte overflow. While `free_to_en` or `master_en` is 1, `src_tick` equals that bit in every cycle.
- R2: While both `master_en` and `free_to_en` are 0, `src_tick` stays 0, overflow strobes have no effect on SCL, `scl_drive_low` stays 0 and no SDA strobe is issued.
- R3: When the line is not stretched and no other master contends, the drive-low request lasts P cycles and the released interval lasts 2P cycles, where P is the overflow period in cycles. The bit period is 3P.
- R4: With `ext_hold_en` at 1 the drive-low request lasts 2P cycles. `sda_change_stb` pulses P cycles after the request rises.
- R5: With `ext_hold_en` at 0, `sda_change_stb` pulses for one cycle, exactly one cycle after `scl_drive_low` rises.
- R6: `sda_sample_stb` pulses one cycle after the first selected overflow of the high phase. When the line is not stretched, this is P cycles after the release.
- R7: A low phase that does not start on an overflow (after enable or after a restart) ends only on the second overflow counted from its first cycle. `scl_drive_low` falls in the cycle after that overflow, so the line is never released before one full overflow interval.
- R8: The high phase starts in the cycle after `scl_in` is first seen high while released. `scl_drive_low` rises in the cycle after the second overflow counted from that start. Overflows that arrive while a slave holds the line low are ignored.
- R9: If `scl_in` is seen low during the high phase while the block is not driving, `scl_drive_low` rises in the next cycle and an unaligned low phase begins (timed per R7).
- R10: Clearing `master_en` drops `scl_drive_low` in the same cycle and returns the phase logic to idle. Setting it again raises `scl_drive_low` one cycle later, as an unaligned low phase.
- R11: After reset, `scl_drive_low`, `sda_change_stb`, `sda_sample_stb` and `src_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_strobe | input | 4 | Overflow strobes of the four timer sources |
| src_sel | input | 2 | Source select, index into `ovf_strobe` |
| master_en | input | 1 | Enables clock generation as bus master |
| free_to_en | input | 1 | Passes the selected strobe to `src_tick` for the bus-free timeout counter |
| ext_hold_en | input | 1 | Lengthens SDA setup and hold by one overflow |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | Request to pull SCL low |
| sda_change_stb | output | 1 | Byte engine may change SDA now |
| sda_sample_stb | output | 1 | Byte engine should sample SDA now |
| src_tick | output | 1 | Gated selected overflow strobe |

## Verification
The hardest cases to reach are a strobe that arrives during a stretched or aborted high phase, and the exact rising edge after synchronisation. Both depend on where the overflow falls relative to the bus events. The bench therefore drives each source as a free-running strobe of known period and tracks those strobe cycles itself. It applies the slave hold while the block is still driving low, so the release lands on an already-low line. It pulls the line for a single cycle straight after a release, which places the contention inside the high phase before any overflow can end it. It then counts overflows from the cycle it knows the block entered the phase, and derives from that count the cycle in which the drive edge must appear.

// File: rtl/smb_scl_pkg.sv
package smb_scl_pkg;

    localparam int unsigned SRC_COUNT = 4;
    localparam int unsigned PH_CNT_W  = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_REL  = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

    // Phase context: current phase, overflow count inside it,
    // first-cycle marker and "an overflow was already seen" marker.
    typedef struct packed {
        scl_phase_e            ph;
        logic [PH_CNT_W-1:0]   cnt;
        logic                  fresh;
        logic                  tick_seen;
    } scl_ctx_t;

    typedef struct packed {
        logic low_fresh;
        logic low_tick1;
        logic high_tick1;
    } scl_evt_t;

    localparam scl_ctx_t CTX_IDLE = '{ph: PH_IDLE, cnt: '0, fresh: 1'b0, tick_seen: 1'b0};

    // Overflow count a low phase must hold before release.
    function automatic logic [PH_CNT_W-1:0] low_need(input logic ext);
        return ext ? PH_CNT_W'(2) : PH_CNT_W'(1);
    endfunction

    // Enter the low phase; an entry on an overflow already counts one interval.
    function automatic scl_ctx_t enter_low(input logic aligned);
        scl_ctx_t c;
        c.ph        = PH_LOW;
        c.cnt       = aligned ? PH_CNT_W'(1) : '0;
        c.fresh     = 1'b1;
        c.tick_seen = 1'b0;
        return c;
    endfunction

    function automatic scl_ctx_t enter_plain(input scl_phase_e p);
        scl_ctx_t c;
        c.ph        = p;
        c.cnt       = '0;
        c.fresh     = 1'b0;
        c.tick_seen = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/smb_tick_sel.sv
module smb_tick_sel
    import smb_scl_pkg::*;
#(
    parameter int unsigned N = SRC_COUNT,
    localparam int unsigned SEL_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     ovf_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             master_en_i,
    input  logic             free_to_en_i,
    output logic             tick_o
);

    logic [N-1:0] hit;

    for (genvar gi = 0; gi < N; gi++) begin : g_src
        assign hit[gi] = ovf_i[gi] && (sel_i == SEL_W'(gi));
    end

    assign tick_o = (master_en_i || free_to_en_i) && (|hit);

endmodule

// File: rtl/smb_scl_phase.sv
module smb_scl_phase
    import smb_scl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       master_en_i,
    input  logic       ext_hold_i,
    input  logic       tick_i,
    input  logic       scl_in_i,
    output scl_phase_e ph_o,
    output scl_evt_t   evt_o
);

    scl_ctx_t ctx, ctx_nx;
    scl_evt_t evt;

    always_comb begin
        ctx_nx = ctx;
        evt    = '0;
        if (!master_en_i) begin
            ctx_nx = CTX_IDLE;
        end else begin
            unique case (ctx.ph)
                PH_IDLE: ctx_nx = enter_low(1'b0);
                PH_LOW: begin
                    ctx_nx.fresh  = 1'b0;
                    evt.low_fresh = ctx.fresh;
                    if (tick_i) begin
                        evt.low_tick1     = !ctx.tick_seen;
                        ctx_nx.tick_seen  = 1'b1;
                        if (ctx.cnt >= low_need(ext_hold_i))
                            ctx_nx = enter_plain(PH_REL);
                        else
                            ctx_nx.cnt = ctx.cnt + PH_CNT_W'(1);
                    end
                end
                PH_REL: begin
                    if (scl_in_i)
                        ctx_nx = enter_plain(PH_HIGH);
                end
                PH_HIGH: begin
                    if (tick_i && (ctx.cnt != '0)) begin
                        ctx_nx = enter_low(1'b1);
                    end else if (!scl_in_i) begin
                        ctx_nx = enter_low(1'b0);
                    end else if (tick_i) begin
                        ctx_nx.cnt     = PH_CNT_W'(1);
                        evt.high_tick1 = 1'b1;
                    end
                end
                default: ctx_nx = CTX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctx <= CTX_IDLE;
        else     ctx <= ctx_nx;
    end

    assign ph_o  = ctx.ph;
    assign evt_o = evt;

    // R10
    idle_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
        !master_en_i |=> (ctx.ph == PH_IDLE));

    // R7
    release_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx.ph == PH_REL && $past(ctx.ph) == PH_LOW) |-> ($past(tick_i) && $past(ctx.cnt) != '0));

    // R8
    high_needs_line_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx.ph == PH_HIGH) |-> $past(scl_in_i));

    // R3
    low_from_high_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx.ph == PH_LOW && $past(ctx.ph) == PH_HIGH) |-> ($past(tick_i) || !$past(scl_in_i)));

endmodule

// File: rtl/smb_sda_strobe.sv
module smb_sda_strobe
    import smb_scl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ext_hold_i,
    input  scl_evt_t evt_i,
    output logic     change_o,
    output logic     sample_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            change_o <= 1'b0;
            sample_o <= 1'b0;
        end else begin
            change_o <= ext_hold_i ? evt_i.low_tick1 : evt_i.low_fresh;
            sample_o <= evt_i.high_tick1;
        end
    end

    // R6
    sample_single_chk: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> !sample_o);

endmodule

// File: rtl/smb_scl_gen.sv
module smb_scl_gen
    import smb_scl_pkg::*;
#(
    parameter int unsigned SRC_N = SRC_COUNT,
    localparam int unsigned SEL_W = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] ovf_strobe,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             master_en,
    input  logic             free_to_en,
    input  logic             ext_hold_en,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             sda_change_stb,
    output logic             sda_sample_stb,
    output logic             src_tick
);

    scl_phase_e ph;
    scl_evt_t   evt;
    logic       tick;

    smb_tick_sel #(.N(SRC_N)) u_sel (
        .ovf_i        (ovf_strobe),
        .sel_i        (src_sel),
        .master_en_i  (master_en),
        .free_to_en_i (free_to_en),
        .tick_o       (tick)
    );

    smb_scl_phase u_phase (
        .clk         (clk),
        .rst         (rst),
        .master_en_i (master_en),
        .ext_hold_i  (ext_hold_en),
        .tick_i      (tick),
        .scl_in_i    (scl_in),
        .ph_o        (ph),
        .evt_o       (evt)
    );

    smb_sda_strobe u_strobe (
        .clk        (clk),
        .rst        (rst),
        .ext_hold_i (ext_hold_en),
        .evt_i      (evt),
        .change_o   (sda_change_stb),
        .sample_o   (sda_sample_stb)
    );

    assign scl_drive_low = (ph == PH_LOW) && master_en;
    assign src_tick      = tick;

    // R5
    change_after_low_chk: assert property (@(posedge clk) disable iff (rst)
        sda_change_stb |-> $past(scl_drive_low));

    // R6
    sample_while_released_chk: assert property (@(posedge clk) disable iff (rst)
        sda_sample_stb |-> !scl_drive_low);

    // R2
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!master_en && !free_to_en) |-> !src_tick);

endmodule

// File: tb/smb_scl_gen_bench.sv
module smb_scl_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ovf = '0;
    logic [1:0] sel = '0;
    logic       men = 1'b0;
    logic       fen = 1'b0;
    logic       ext = 1'b0;
    logic       slave_hold = 1'b0;
    logic       other_pull = 1'b0;
    logic       drv, chg, smp, tck;
    wire        line = !(drv || slave_hold || other_pull);

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2 clk = !clk;

    smb_scl_gen u_smb_scl_gen (
        .clk(clk), .rst(rst), .ovf_strobe(ovf), .src_sel(sel),
        .master_en(men), .free_to_en(fen), .ext_hold_en(ext),
        .scl_in(line), .scl_drive_low(drv), .sda_change_stb(chg),
        .sda_sample_stb(smp), .src_tick(tck)
    );

    // Source i overflows every 4+i cycles.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc = cyc + 1;
            for (int i = 0; i < 4; i++) ovf[i] = ((cyc % (4 + i)) == 0);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic at_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_drv(input logic v);
        do @(negedge clk); while (drv !== v);
    endtask

    task automatic do_reset();
        at_edge();
        rst = 1'b1;
        men = 1'b0;
        slave_hold = 1'b0;
        other_pull = 1'b0;
        at_edge();
        at_edge();
        rst = 1'b0;
    endtask

    // Current negedge is the first cycle of an unaligned low phase.
    task automatic low_from_entry(input string req);
        int n = 0;
        int bad = 0;
        for (int k = 0; k < 60; k++) begin
            if (n == 2) begin
                chk(req, drv, 0);
                break;
            end
            if (drv !== 1'b1) bad++;
            if (ovf[sel]) n++;
            @(negedge clk);
        end
        chk(req, bad, 0);
    endtask

    task automatic run_cfg(input int s, input logic e);
        int p = 4 + s;
        int t_rise = 0, t_fall = 0, nr = 0, nf = 0;
        logic pd = 1'b0;
        do_reset();
        sel = 2'(s);
        ext = e;
        men = 1'b1;
        for (int k = 0; k < 14 * p; k++) begin
            @(negedge clk);
            if (drv && !pd) begin
                if (nf >= 2) chk("R3 released length", cyc - t_fall, 2 * p);
                t_rise = cyc;
                nr++;
            end
            if (!drv && pd) begin
                if (nr >= 2) chk(e ? "R4 low length" : "R3 low length", cyc - t_rise, e ? 2 * p : p);
                t_fall = cyc;
                nf++;
            end
            if (chg && nr >= 2) chk(e ? "R4 change delay" : "R5 change delay", cyc - t_rise, e ? p : 1);
            if (smp && nf >= 2) chk("R6 sample delay", cyc - t_fall, p);
            pd = drv;
        end
    endtask

    initial begin
        int bad;
        int n;
        int r_ok;
        int k1;
        // R11 reset state
        @(negedge clk);
        @(negedge clk);
        chk("R11 drive", drv, 0);
        chk("R11 change", chg, 0);
        chk("R11 sample", smp, 0);
        chk("R11 tick", tck, 0);
        rst = 1'b0;

        // R2: everything off
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (tck || drv || chg || smp) bad++;
        end
        chk("R2 ignored strobes", bad, 0);

        // R1: free-timeout path exposes each source
        fen = 1'b1;
        for (int s = 0; s < 4; s++) begin
            at_edge();
            sel = 2'(s);
            bad = 0;
            n = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (tck !== ovf[s]) bad++;
                if (drv) bad++;
                if (tck) n++;
            end
            chk("R1 tick mismatch", bad, 0);
            chk("R1 tick count", n, 30 / (4 + s) + ((n > 30 / (4 + s)) ? 1 : 0));
        end
        at_edge();
        fen = 1'b0;

        // R3..R6 sweep over all sources and both hold modes
        for (int s = 0; s < 4; s++)
            for (int e = 0; e < 2; e++) run_cfg(s, e[0]);

        // R8: slave stretches the low phase
        do_reset();
        sel = 2'd1;
        ext = 1'b0;
        men = 1'b1;
        for (int k = 0; k < 3; k++) begin wait_drv(1); wait_drv(0); end
        wait_drv(1);
        at_edge();
        slave_hold = 1'b1;
        wait_drv(0);
        bad = 0;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            if (drv || smp) bad++;
        end
        chk("R8 held line", bad, 0);
        at_edge();
        slave_hold = 1'b0;
        @(negedge clk);
        n = 0; bad = 0; r_ok = 0; k1 = -1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (k1 >= 0 && cyc == k1 + 1) chk("R6 sample after stretch", smp, 1);
            if (n == 2) begin
                r_ok = drv;
                break;
            end
            if (drv) bad++;
            if (ovf[1]) begin
                n++;
                if (n == 1) k1 = cyc;
            end
        end
        chk("R8 early drive", bad, 0);
        chk("R8 drive edge", r_ok, 1);

        // R9: other master pulls inside the high phase
        wait_drv(1);
        wait_drv(0);
        at_edge();
        other_pull = 1'b1;
        at_edge();
        other_pull = 1'b0;
        @(negedge clk);
        chk("R9 resync drive", drv, 1);
        low_from_entry("R9 resync low");

        // R10 and R7: disable mid-low, then re-enable
        wait_drv(1);
        at_edge();
        men = 1'b0;
        @(negedge clk);
        chk("R10 immediate release", drv, 0);
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (drv || chg || smp) bad++;
        end
        chk("R10 stays idle", bad, 0);
        at_edge();
        men = 1'b1;
        @(negedge clk);
        chk("R10 enable cycle", drv, 0);
        @(negedge clk);
        chk("R10 restart drive", drv, 1);
        low_from_entry("R7 unaligned low");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule